// File: doc/BRIEF.md
# DMA Control Register Block

This block is the software-visible control surface of a simple memory-write engine. A processor reaches it over a single-beat read/write request bus. A request belongs to the block when its address agrees with a configured base on every bit that a configured mask leaves clear. Inside that window the block holds four registers: the destination address of a transfer, the transfer length in bytes, a run flag that starts the engine, and a completion flag that the engine raises when it is done.

The engine sees the address, the length and the run flag as plain outputs. It reports the end of a transfer with a one-cycle pulse, which clears the run flag and sets the completion flag together. The completion flag drives a level interrupt directly. The interrupt stays high until software writes zero to the completion register, so a driver may either poll the flag or wait for the interrupt.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset the address and length registers are zero, the run and completion flags are clear, `irq` is low and `resp_valid` is low.
- R2: A request hits when `((req_addr ^ BASE) & ~MASK) == 0`. A request that misses gets no response and changes no register.
- R3: Every hit request, read or write, raises `resp_valid` for exactly one cycle, in the cycle after the request is accepted. Write responses carry zero read data.
- R4: Offset 0x00 is the destination address register. A write loads the low ADDR_W bits of the write data. A read returns the register zero-extended to DATA_W.
- R5: Offset 0x08 is the length register. It has the same width and the same write and read behaviour as the address register.
- R6: Offset 0x10 is the run flag. A write loads bit 0 of the write data, and a read returns the flag in bit 0 with all other bits zero.
- R7: Offset 0x18 is the completion flag, returned in bit 0 on a read. A write with bit 0 equal to 0 clears the flag. A write with bit 0 equal to 1 has no effect.
- R8: An `eng_done` pulse sets the completion flag and clears the run flag on the next clock edge. In that cycle it takes priority over a software write to either flag.
- R9: `irq` equals the completion flag, so it stays high from the done pulse until software clears the flag.
- R10: The register is selected by address bits [5:3], and bits [2:0] are ignored. Selector values 4 to 7 (offsets 0x20 to 0x38) read as zero, and writes to them are ignored.
- R11: `eng_addr`, `eng_len` and `eng_run` always show the current contents of the address register, the length register and the run flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response for the request of the previous cycle |
| resp_rdata | output | DATA_W | Read data of the response |
| eng_addr | output | ADDR_W | Destination address given to the engine |
| eng_len | output | ADDR_W | Transfer length in bytes given to the engine |
| eng_run | output | 1 | Run flag given to the engine |
| eng_done | input | 1 | One-cycle pulse from the engine when a transfer finishes |
| irq | output | 1 | Level interrupt that follows the completion flag |

## Verification
The bench sends accesses to addresses that differ from the base in a single bit above the mask. A decoder that compares too few bits would answer them, or its registers would take the write. Software writes to the run and completion flags are sent in the same cycle as a done pulse. A design with the priority reversed would leave the engine running, or would lose an interrupt. Other corner cases are writes of 1 to the completion flag, which must not set it, and accesses with nonzero low address bits, which must reach the same register. Writes to the four unused offsets must not disturb any register. Every value read back is compared with a model of the registers that the bench keeps.

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] BASE = 'h1001_7000,
  parameter logic [ADDR_W-1:0] MASK = 'h3f
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [ADDR_W-1:0] eng_len,
  output logic              eng_run,
  input  logic              eng_done,
  output logic              irq
);
  localparam int SEL_LO = 3;
  localparam int SEL_W  = 3;
  localparam logic [SEL_W-1:0] SEL_ADDR = 3'd0;
  localparam logic [SEL_W-1:0] SEL_LEN  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_RUN  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_DONE = 3'd3;

  logic [ADDR_W-1:0] addr_q, len_q;
  logic              run_q, done_q;
  logic [DATA_W-1:0] rmux;

  wire              hit = ((req_addr ^ BASE) & ~MASK) == '0;
  wire [SEL_W-1:0]  sel = req_addr[SEL_LO +: SEL_W];
  wire              acc = req_valid & hit;
  wire              wr  = acc & req_write;
  wire              rd  = acc & ~req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      if (wr && sel == SEL_ADDR) addr_q <= req_wdata[ADDR_W-1:0];
      if (wr && sel == SEL_LEN)  len_q  <= req_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (eng_done) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end else begin
      if (wr && sel == SEL_RUN) run_q <= req_wdata[0];
      if (wr && sel == SEL_DONE && !req_wdata[0]) done_q <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_ADDR: rmux = DATA_W'(addr_q);
      SEL_LEN:  rmux = DATA_W'(len_q);
      SEL_RUN:  rmux = DATA_W'(run_q);
      SEL_DONE: rmux = DATA_W'(done_q);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= acc;
      resp_rdata <= rd ? rmux : '0;
    end
  end

  assign eng_addr = addr_q;
  assign eng_len  = len_q;
  assign eng_run  = run_q;
  assign irq      = done_q;
endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 'h1001_7000,
  parameter logic [ADDR_W-1:0] MASK = 'h3f
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              wbit0,
  input logic              resp_valid,
  input logic              eng_run,
  input logic              eng_done,
  input logic              irq
);
  wire in_win = ((req_addr ^ BASE) & ~MASK) == '0;
  wire clr_wr = req_valid && req_write && in_win && req_addr[5:3] == 3'd3 && !wbit0;
  wire run_wr = req_valid && req_write && in_win && req_addr[5:3] == 3'd2;

  a_r3_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_win) |=> resp_valid);
  a_r2_no_resp_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && in_win) |=> !resp_valid);
  a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (irq && !eng_run));
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !eng_done) |=> !irq);
  a_r6_run_load: assert property (@(posedge clk) disable iff (!rst_n)
    (run_wr && !eng_done) |=> (eng_run == $past(wbit0)));
endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .MASK(MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .wbit0(req_wdata[0]), .resp_valid(resp_valid),
  .eng_run(eng_run), .eng_done(eng_done), .irq(irq)
);

// File: tb/dma_ctrl_regs_test.sv
`timescale 1ns/1ps
module dma_ctrl_regs_test;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [AW-1:0] BASE = 32'h1001_7000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, eng_done = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic resp_valid, eng_run, irq;
  logic [DW-1:0] resp_rdata;
  logic [AW-1:0] eng_addr, eng_len;

  always #2.5 clk = ~clk;

  dma_ctrl_regs uut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .eng_addr(eng_addr), .eng_len(eng_len), .eng_run(eng_run), .eng_done(eng_done), .irq(irq));

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [AW-1:0] m_addr = '0, m_len = '0;
  logic m_run = 0, m_done = 0;

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [2:0] s);
    case (s)
      3'd0: return DW'(m_addr);
      3'd1: return DW'(m_len);
      3'd2: return DW'(m_run);
      3'd3: return DW'(m_done);
      default: return '0;
    endcase
  endfunction

  function automatic bit in_win(input logic [AW-1:0] a);
    return ((a ^ BASE) & ~AW'(32'h3f)) == '0;
  endfunction

  task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit done);
    logic [DW-1:0] er;
    bit h;
    h = in_win(a);
    er = (h && !w) ? exp_read(a[5:3]) : '0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; eng_done = done;
    @(posedge clk); #1;
    req_valid = 0; eng_done = 0;
    chk(resp_valid == h, h ? "R3 response" : "R2 miss", DW'(resp_valid), DW'(h));
    if (h) chk(resp_rdata == er, w ? "R3 write data" : "R10 read", resp_rdata, er);
    if (h && w) begin
      case (a[5:3])
        3'd0: m_addr = d[AW-1:0];
        3'd1: m_len = d[AW-1:0];
        3'd2: m_run = d[0];
        3'd3: if (!d[0]) m_done = 0;
        default: ;
      endcase
    end
    if (done) begin m_run = 0; m_done = 1; end
    chk(eng_addr == m_addr, "R4 R11 addr", DW'(eng_addr), DW'(m_addr));
    chk(eng_len == m_len, "R5 R11 len", DW'(eng_len), DW'(m_len));
    chk(eng_run == m_run, "R6 R8 run", DW'(eng_run), DW'(m_run));
    chk(irq == m_done, "R7 R9 irq", DW'(irq), DW'(m_done));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #12 rst_n = 1;
    @(negedge clk);
    chk(!resp_valid && !irq && !eng_run && eng_addr == 0 && eng_len == 0, "R1 reset",
        {eng_addr, 29'd0, resp_valid, irq, eng_run}, '0);
    // directed
    access(1, BASE + 32'h00, 64'hffff_ffff_1234_5678, 0);
    access(0, BASE + 32'h00, '0, 0);
    access(1, BASE + 32'h0d, 64'h0000_0000_0000_0040, 0);
    access(0, BASE + 32'h08, '0, 0);
    access(1, BASE + 32'h18, 64'h1, 0);
    access(1, BASE + 32'h10, 64'h1, 0);
    access(0, BASE + 32'h10, '0, 0);
    access(1, BASE + 32'h10, 64'h1, 1);
    access(0, BASE + 32'h18, '0, 0);
    access(1, BASE + 32'h18, 64'h0, 1);
    access(1, BASE + 32'h18, 64'h0, 0);
    access(1, BASE ^ 32'h40, 64'hdead, 0);
    access(1, BASE ^ 32'h8000_0000, 64'hbeef, 0);
    access(1, BASE + 32'h28, 64'hffff_ffff_ffff_ffff, 0);
    access(0, BASE + 32'h38, '0, 0);
    // random
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      a = BASE | AW'($urandom % 64);
      if ($urandom % 6 == 0) a = a ^ (AW'(1) << (6 + $urandom % 26));
      access(($urandom % 2) == 1, a, {$urandom, $urandom}, ($urandom % 8) == 0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule